// File: doc/BRIEF.md
# Connection memory block initializer

This block loads one common word into every location of a switch connection memory on a single register command. It sits between the mode register, the control register's block-program mode bit and the connection memory write port. Software first raises the block-program mode bit. It then writes the mode register with a 5-bit fill pattern and the start bit set. The block sweeps the whole memory, one location per clock. Each location gets the pattern in its upper five bits and zeros in its lower eleven. When the sweep is over, the start bit drops by itself.

The same write port also carries normal microport writes to the connection memory. The block arbitrates between the two sources. An idle block passes a microport write through in the same cycle and acknowledges it. During a sweep it holds the acknowledge low, and the write waits until the sweep has ended. If the mode bit is lowered during a sweep, the sweep stops at once and the start bit clears.

The controller has two named states:
- `FILL_IDLE`: the memory port follows the microport, and the start bit reads 0.
- `FILL_SWEEP`: the address counter drives the port, and the start bit reads 1.

There are three transitions:
- launch: `FILL_IDLE` to `FILL_SWEEP`, on a mode write with the start bit set while the mode bit is high.
- finish: `FILL_SWEEP` to `FILL_IDLE`, after the write to the last address.
- abort: `FILL_SWEEP` to `FILL_IDLE`, when the mode bit is low.

Top module: `cmem_fill_ctrl`

## Requirements
- R1: After reset, `mode_q` reads 0, `mem_we` is low and `up_ack` is low.
- R2: A mode write with bit 4 (start) set has no effect on the start bit or the memory while `blk_mode` is low. `mode_q[4]` stays 0 and no memory write occurs.
- R3: A mode write with bit 4 set while `blk_mode` is high and no sweep is running starts a sweep. The sweep writes addresses 0 to DEPTH-1 in increasing order, one per clock, with the first write in the cycle after the launching write.
- R4: Every sweep write carries `{pattern, 11'b0}`, where `pattern` is bits 9:5 of the mode write that launched the sweep.
- R5: `mode_q[4]` reads 1 from the cycle after launch through the cycle of the write to address DEPTH-1, and reads 0 from the following cycle.
- R6: While a sweep runs, a microport write (`up_wr`) gets `up_ack` low and is not put on the memory port. A write that is held through the sweep is acknowledged and performed in the first cycle after the sweep ends.
- R7: With no sweep running, `up_wr` gives `up_ack` high in the same cycle, and the memory port carries `up_addr` and `up_wdata`.
- R8: If `blk_mode` is low during a sweep, no memory write occurs in that cycle, and `mode_q[4]` reads 0 from the next cycle. Locations not yet reached keep their previous contents.
- R9: A mode write during a sweep updates the stored pattern field `mode_q[9:5]`. It neither restarts nor stops the sweep, which keeps its address order and its launch pattern.
- R10: A full sweep lasts DEPTH cycles, which is no more than two frame periods of FRAME_CYCLES clocks each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_mode | input | 1 | Block-program mode bit from the control register |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 16 | Mode register write data; bit 4 is start, bits 9:5 are the pattern |
| mode_q | output | 16 | Mode register readback; bit 4 is the live start bit |
| up_wr | input | 1 | Microport connection memory write request |
| up_addr | input | ADDR_W | Microport write address |
| up_wdata | input | 16 | Microport write data |
| up_ack | output | 1 | Microport write accepted this cycle |
| mem_we | output | 1 | Connection memory write enable |
| mem_addr | output | ADDR_W | Connection memory write address |
| mem_wdata | output | 16 | Connection memory write data |

## Verification
A sweep write and a microport write can both request the memory port in the same cycle. The bench provokes this in two ways. First, it raises `up_wr` in the middle of a sweep and holds it past the last sweep address. It checks that `up_ack` stays low through the cycle of address DEPTH-1 and rises in exactly the next cycle. It also checks that the held word lands in a location the sweep had already filled. Second, it writes the mode register during a sweep and checks that the address sequence and the fill data are undisturbed while the stored pattern field changes.

// File: rtl/cmem_fill_pkg.sv
package cmem_fill_pkg;

    typedef enum logic [0:0] {
        FILL_IDLE  = 1'b0,
        FILL_SWEEP = 1'b1
    } fill_state_e;

    localparam int WORD_W       = 16;
    localparam int PAT_W        = 5;
    localparam int MODE_PAT_LSB = 5;
    localparam int MODE_GO_BIT  = 4;
    localparam int ZERO_W       = WORD_W - PAT_W;

    function automatic logic [WORD_W-1:0] fill_word(input logic [PAT_W-1:0] pat);
        return {pat, {ZERO_W{1'b0}}};
    endfunction

endpackage

// File: rtl/cmem_fill_fsm.sv
module cmem_fill_fsm
    import cmem_fill_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic blk_mode,
    input  logic at_last,
    output logic busy,
    output logic cnt_clr,
    output logic cnt_en,
    output logic sweep_we
);

    fill_state_e state_q;
    fill_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: begin
                if (launch) begin
                    state_d = FILL_SWEEP;
                end
            end
            FILL_SWEEP: begin
                if (!blk_mode) begin
                    state_d = FILL_IDLE;
                end else if (at_last) begin
                    state_d = FILL_IDLE;
                end
            end
            default: state_d = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy     = 1'b0;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        sweep_we = 1'b0;
        unique case (state_q)
            FILL_IDLE: begin
                cnt_clr = 1'b1;
            end
            FILL_SWEEP: begin
                busy     = 1'b1;
                sweep_we = blk_mode;
                cnt_en   = blk_mode;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmem_fill_addr.sv
module cmem_fill_addr #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (en) begin
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
        end
    end

    assign at_last = (addr == LAST);

endmodule

// File: rtl/cmem_fill_regs.sv
module cmem_fill_regs
    import cmem_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              launch,
    output logic [WORD_W-1:0] stored,
    output logic [PAT_W-1:0]  pat_run
);

    logic [WORD_W-1:0] go_mask;

    always_comb begin
        go_mask = '1;
        go_mask[MODE_GO_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored  <= '0;
            pat_run <= '0;
        end else begin
            if (wr) begin
                stored <= wdata & go_mask;
            end
            if (launch) begin
                pat_run <= wdata[MODE_PAT_LSB +: PAT_W];
            end
        end
    end

endmodule

// File: rtl/cmem_fill_arb.sv
module cmem_fill_arb
    import cmem_fill_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              busy,
    input  logic              sweep_we,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic [PAT_W-1:0]  sweep_pat,
    input  logic              up_wr,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [WORD_W-1:0] up_wdata,
    output logic              up_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    always_comb begin
        up_ack = up_wr && !busy;
        if (busy) begin
            mem_we    = sweep_we;
            mem_addr  = sweep_addr;
            mem_wdata = fill_word(sweep_pat);
        end else begin
            mem_we    = up_ack;
            mem_addr  = up_addr;
            mem_wdata = up_wdata;
        end
    end

endmodule

// File: rtl/cmem_fill_ctrl.sv
module cmem_fill_ctrl
    import cmem_fill_pkg::*;
#(
    parameter  int STREAMS      = 4,
    parameter  int CHANS        = 32,
    parameter  int FRAME_CYCLES = 256,
    localparam int DEPTH        = STREAMS * CHANS,
    localparam int ADDR_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_mode,
    input  logic              mode_wr,
    input  logic [15:0]       mode_wdata,
    output logic [15:0]       mode_q,
    input  logic              up_wr,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [15:0]       up_wdata,
    output logic              up_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata
);

    logic              busy;
    logic              launch;
    logic              cnt_clr;
    logic              cnt_en;
    logic              sweep_we;
    logic              at_last;
    logic [ADDR_W-1:0] sweep_addr;
    logic [WORD_W-1:0] stored;
    logic [PAT_W-1:0]  pat_run;

    assign launch = mode_wr && mode_wdata[MODE_GO_BIT] && blk_mode && !busy;

    cmem_fill_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .blk_mode (blk_mode),
        .at_last  (at_last),
        .busy     (busy),
        .cnt_clr  (cnt_clr),
        .cnt_en   (cnt_en),
        .sweep_we (sweep_we)
    );

    cmem_fill_addr #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .en      (cnt_en),
        .addr    (sweep_addr),
        .at_last (at_last)
    );

    cmem_fill_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .wdata   (mode_wdata),
        .launch  (launch),
        .stored  (stored),
        .pat_run (pat_run)
    );

    cmem_fill_arb #(
        .ADDR_W (ADDR_W)
    ) u_arb (
        .busy       (busy),
        .sweep_we   (sweep_we),
        .sweep_addr (sweep_addr),
        .sweep_pat  (pat_run),
        .up_wr      (up_wr),
        .up_addr    (up_addr),
        .up_wdata   (up_wdata),
        .up_ack     (up_ack),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    always_comb begin
        mode_q = stored;
        mode_q[MODE_GO_BIT] = busy;
    end

endmodule

// File: rtl/cmem_fill_chk.sv
module cmem_fill_chk #(
    parameter int DEPTH        = 128,
    parameter int ADDR_W       = 7,
    parameter int FRAME_CYCLES = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blk_mode,
    input logic [15:0]       mode_q,
    input logic              up_wr,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              busy
);

    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);
    localparam int                LIM   = 2 * FRAME_CYCLES;
    localparam int                CNT_W = $clog2(LIM + 2) + 1;

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_we && mode_q == 16'h0000));

    p_no_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[4] && !blk_mode) |=> !mode_q[4]);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_mode && mem_addr != LAST) |=>
        (!busy || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_wdata[10:0] == 11'd0));

    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_mode && mem_addr == LAST) |=> !mode_q[4]);

    p_block_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !up_ack);

    p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && up_wr) |-> (up_ack && mem_we && mem_addr == up_addr));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !blk_mode) |-> (!mem_we ##1 !mode_q[4]));

    p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(LIM)));

endmodule

bind cmem_fill_ctrl cmem_fill_chk #(
    .DEPTH        (DEPTH),
    .ADDR_W       (ADDR_W),
    .FRAME_CYCLES (FRAME_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_mode  (blk_mode),
    .mode_q    (mode_q),
    .up_wr     (up_wr),
    .up_addr   (up_addr),
    .up_ack    (up_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy)
);

// File: tb/sim_cmem_fill_ctrl.sv
`timescale 1ns/100ps
module sim_cmem_fill_ctrl;

    localparam int DEPTH  = 128;
    localparam int ADDR_W = 7;
    localparam int NVEC   = 4;
    // each vector: {pattern[4:0], preload junk[15:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {5'b11111, 16'h0000},
        {5'b00000, 16'hFFFF},
        {5'b10101, 16'h5A5A},
        {5'b01010, 16'hC3C3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_mode = 1'b0;
    logic              mode_wr = 1'b0;
    logic [15:0]       mode_wdata = '0;
    logic [15:0]       mode_q;
    logic              up_wr = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [15:0]       up_wdata = '0;
    logic              up_ack;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_wdata;

    cmem_fill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .mode_q(mode_q), .up_wr(up_wr), .up_addr(up_addr),
        .up_wdata(up_wdata), .up_ack(up_ack), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    always #2 clk = ~clk;

    logic [15:0] model [DEPTH];
    int          wr_total = 0;
    int          nxt = 0;
    int          seq_err = 0;
    int          data_err = 0;
    logic        track = 1'b0;
    logic [4:0]  exp_pat = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    // write monitor: the port is stable at the falling edge
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            model[mem_addr] = mem_wdata;
            wr_total++;
            if (track) begin
                if (int'(mem_addr) != nxt) seq_err++;
                if (mem_wdata != {exp_pat, 11'b0}) data_err++;
                nxt++;
                if (nxt == DEPTH) track = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic peek();
        @(negedge clk);
        #0.5;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic launch(input logic [4:0] pat, input bit go);
        mode_wr    = 1'b1;
        mode_wdata = {6'b0, pat, go, 4'b0};
        if (go && blk_mode && !mode_q[4]) begin
            track   = 1'b1;
            nxt     = 0;
            seq_err = 0;
            data_err = 0;
            exp_pat = pat;
        end
        tick(1);
        mode_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int base;
        int bad;
        logic [4:0] prev_pat;

        tick(3);
        peek();
        check(mode_q == 16'h0 && !mem_we && !up_ack, "R1 reset state",
              {mode_q, mem_we, up_ack}, 0);
        rst_n = 1'b1;
        tick(2);

        // R2: start bit ignored with mode bit low
        base = wr_total;
        launch(5'b11011, 1'b1);
        tick(3);
        peek();
        check(mode_q[4] == 1'b0, "R2 start bit without mode", mode_q[4], 0);
        check(wr_total == base, "R2 no memory write without mode", wr_total - base, 0);
        blk_mode = 1'b1;

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0]  pat;
            logic [15:0] junk;
            pat  = VEC[v][20:16];
            junk = VEC[v][15:0];
            bad  = 0;
            for (int a = 0; a < DEPTH; a++) begin
                up_wr    = 1'b1;
                up_addr  = ADDR_W'(a);
                up_wdata = junk ^ 16'(a);
                @(negedge clk);
                if (!up_ack) bad++;
                tick(1);
            end
            up_wr = 1'b0;
            for (int a = 0; a < DEPTH; a++) begin
                if (model[a] !== (junk ^ 16'(a))) bad++;
            end
            check(bad == 0, "R7 idle microport preload", bad, 0);

            launch(pat, 1'b1);
            tick(DEPTH - 1);
            peek();
            check(mode_q[4] == 1'b1, "R5 start bit high at last address", mode_q[4], 1);
            tick(1);
            peek();
            check(mode_q[4] == 1'b0, "R5 start bit self clears", mode_q[4], 0);
            check(nxt == DEPTH && seq_err == 0, "R3 address order and count", nxt, DEPTH);
            check(data_err == 0, "R4 fill data split", data_err, 0);
            bad = 0;
            for (int a = 0; a < DEPTH; a++) begin
                if (model[a] !== {pat, 11'b0}) bad++;
            end
            check(bad == 0, "R4 every location filled", bad, 0);
            check(mode_q[9:5] == pat, "R9 stored pattern field", mode_q[9:5], pat);
        end
        prev_pat = VEC[NVEC-1][20:16];

        // R8: abort by clearing the mode bit
        base = wr_total;
        launch(5'b00111, 1'b1);
        tick(10);
        blk_mode = 1'b0;
        peek();
        check(!mem_we, "R8 no write in abort cycle", mem_we, 0);
        tick(1);
        peek();
        check(mode_q[4] == 1'b0, "R8 start bit cleared on abort", mode_q[4], 0);
        check(wr_total - base == 10, "R8 writes before abort", wr_total - base, 10);
        check(model[9] == {5'b00111, 11'b0} && model[10] == {prev_pat, 11'b0},
              "R8 untouched tail", model[10], {prev_pat, 11'b0});
        tick(3);
        blk_mode = 1'b1;
        track = 1'b0;

        // R6: microport write held across the end of a sweep
        launch(5'b10001, 1'b1);
        tick(5);
        up_wr    = 1'b1;
        up_addr  = 7'd3;
        up_wdata = 16'hBEEF;
        peek();
        check(!up_ack && !(mem_we && mem_wdata == 16'hBEEF), "R6 blocked during sweep",
              up_ack, 0);
        tick(DEPTH - 6);
        peek();
        check(!up_ack && mode_q[4], "R6 still blocked at last address", up_ack, 0);
        tick(1);
        peek();
        check(up_ack && mem_we && mem_addr == 7'd3, "R6 granted after sweep", up_ack, 1);
        tick(1);
        up_wr = 1'b0;
        peek();
        check(model[3] == 16'hBEEF, "R6 held word landed", model[3], 16'hBEEF);
        check(model[4] == {5'b10001, 11'b0}, "R6 neighbour keeps fill", model[4],
              {5'b10001, 11'b0});

        // R9: mode write during sweep neither restarts nor changes the fill
        launch(5'b01100, 1'b1);
        tick(3);
        mode_wr    = 1'b1;
        mode_wdata = {6'b0, 5'b10011, 1'b1, 4'b0};
        tick(1);
        mode_wr = 1'b0;
        peek();
        check(mode_q[4] == 1'b1 && mode_q[9:5] == 5'b10011, "R9 field updated mid sweep",
              mode_q[9:5], 5'b10011);
        tick(DEPTH - 4);
        peek();
        check(mode_q[4] == 1'b0, "R10 sweep ends after DEPTH cycles", mode_q[4], 0);
        check(nxt == DEPTH && seq_err == 0 && data_err == 0, "R9 sweep undisturbed",
              seq_err + data_err, 0);

        tick(2);
        summary();
    end

endmodule